// File: doc/BRIEF.md
# PCM Time-Slot Assignment Unit

This block places one transmit channel and one receive channel on a frame-synchronised serial PCM bus that has two transmit lines and two receive lines. Software writes an 8-bit slot byte for each direction. The byte says whether the direction is on, which of the two lines it uses and which 8-bit slot of the frame it takes. A separate one-bit timing mode selects one of two timings. In fixed timing, the channel always sits in the first eight bit clocks after the frame sync. In assigned timing, the slot is placed by its number, one bit clock later than the fixed position.

Each direction has its own frame-sync input and its own position counter. The transmit frame and the receive frame can therefore be offset from each other by any whole number of bit clocks. During the active slot the block raises a per-line enable: for transmit, this is the output enable of the line driver; for receive, it is the capture strobe of the line. It also reports the index of the current bit within the slot. Outside the slot every enable is low, so the transmit lines can float.

A direction copies the pending slot byte and timing mode into its working set only when a frame starts. A write made in the middle of a frame therefore never moves a slot that is already in progress.

Each direction runs a four-state machine:
- `ST_NOSYNC`: no frame seen since reset.
- `ST_LEAD`: the frame has started and the slot is still ahead.
- `ST_ACTIVE`: inside the slot.
- `ST_TRAIL`: the slot is over, or the direction is off for this frame.

The transitions are:
- Any state goes to `ST_ACTIVE`, `ST_LEAD` or `ST_TRAIL` on a frame start, depending on the new slot start and the enable bit.
- `ST_LEAD` goes to `ST_ACTIVE` when the position reaches the slot start.
- `ST_ACTIVE` goes to `ST_TRAIL` when the position reaches the slot start plus 8.
- `ST_NOSYNC` and `ST_TRAIL` otherwise hold.

Top module: `pcm_slot_assign`

## Requirements
- R1: A slot byte is loaded into the transmit or receive pending register when `wr_tx` or `wr_rx` is high on a clock edge. Its fields are bit 7 = enable, bit 6 = line select and bits 5..0 = slot number (bit 5 is the MSB).
- R2: After reset, both pending bytes are 0 and the timing mode is fixed. Every enable and bit index stays 0, including while frame syncs arrive.
- R3: A frame starts on a clock edge where the frame sync is sampled high after being sampled low on the previous edge. Holding the sync high does not restart the frame. The cycle after the frame-start edge is position 0, and the position increments on every following edge.
- R4: In fixed timing, the slot covers positions 0 through 7 whatever the slot number.
- R5: In assigned timing, slot N covers positions 8N+1 through 8N+8.
- R6: With enable = 0, both enables of that direction stay low for the whole frame.
- R7: With enable = 1, only the enable bit numbered by the line select is high during the slot (bit 0 = line 0, bit 1 = line 1). At most one bit is ever high.
- R8: During the slot, the bit index equals the position minus the slot start (0 to 7), rising by one each cycle. Outside the slot it is 0.
- R9: A slot byte or mode written during a frame does not change that frame. It takes effect at the next frame start of that direction.
- R10: Transmit and receive use separate frame syncs and counters. Each follows its own sync whatever the phase between the two.
- R11: `wr_mode` loads `wr_data[0]` into the timing mode: 0 = fixed, 1 = assigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| wr_tx | input | 1 | Load `wr_data` as pending transmit slot byte |
| wr_rx | input | 1 | Load `wr_data` as pending receive slot byte |
| wr_mode | input | 1 | Load `wr_data[0]` as pending timing mode |
| wr_data | input | 8 | Slot byte or mode bit |
| tx_oe | output | 2 | Per-line transmit output enable |
| tx_bit | output | 3 | Bit index inside the transmit slot |
| rx_stb | output | 2 | Per-line receive capture strobe |
| rx_bit | output | 3 | Bit index inside the receive slot |

## Verification
A write is registered on the edge after the strobe, and a frame start is registered on the edge where the sync is first seen high. The enables and bit index are decoded from registered state, so they show position 0 in the cycle directly after that edge. The bench drives inputs on falling edges and treats the n-th falling edge after the sync is raised as position n-1. For the receive side it shifts this count by its own sync delay. It compares both directions on every falling edge of every frame, across all 64 slot numbers in assigned timing. Mid-frame writes are placed several cycles after the frame-start edge, and the new value is expected only in the next frame.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;

    localparam int TSA_SLOT_W = 6;
    localparam int TSA_BIT_W  = 3;
    localparam int TSA_PORTS  = 2;

    typedef enum logic [1:0] {
        ST_NOSYNC = 2'd0,
        ST_LEAD   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_TRAIL  = 2'd3
    } slot_state_e;

    typedef enum logic {
        TM_FIXED    = 1'b0,
        TM_ASSIGNED = 1'b1
    } timing_mode_e;

endpackage

// File: rtl/pcm_tsa_cfg_regs.sv
module pcm_tsa_cfg_regs
    import pcm_tsa_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_tx,
    input  logic             wr_rx,
    input  logic             wr_mode,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] pend_tx,
    output logic [CFG_W-1:0] pend_rx,
    output timing_mode_e     pend_mode
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_tx   <= '0;
            pend_rx   <= '0;
            pend_mode <= TM_FIXED;
        end else begin
            if (wr_tx)   pend_tx   <= wr_data;
            if (wr_rx)   pend_rx   <= wr_data;
            if (wr_mode) pend_mode <= timing_mode_e'(wr_data[0]);
        end
    end

endmodule

// File: rtl/pcm_tsa_frame_edge.sv
module pcm_tsa_frame_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fs,
    output logic frame_start
);

    logic fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fs;
    end

    assign frame_start = fs & ~fs_q;

endmodule

// File: rtl/pcm_tsa_slot_engine.sv
module pcm_tsa_slot_engine
    import pcm_tsa_pkg::*;
#(
    parameter int SLOT_W = TSA_SLOT_W,
    parameter int BIT_W  = TSA_BIT_W,
    parameter int SEL_W  = 1,
    localparam int CFG_W = SLOT_W + SEL_W + 1,
    localparam int POS_W = SLOT_W + BIT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CFG_W-1:0] pend_cfg,
    input  timing_mode_e     pend_mode,
    output logic             slot_active,
    output logic [SEL_W-1:0] slot_sel,
    output logic [BIT_W-1:0] bit_idx
);

    localparam logic [POS_W-1:0] SLOT_LEN = POS_W'(1 << BIT_W);
    localparam logic [POS_W-1:0] POS_MAX  = {POS_W{1'b1}};

    slot_state_e      state_q, state_n;
    logic [POS_W-1:0] pos_q, pos_n, pos_inc;
    logic [POS_W-1:0] start_q, start_n, new_start;
    logic [SEL_W-1:0] sel_q, sel_n;
    logic             new_en;

    // First position of the slot for a given byte and timing mode
    always_comb begin
        new_en = pend_cfg[CFG_W-1];
        if (pend_mode == TM_ASSIGNED)
            new_start = {1'b0, pend_cfg[SLOT_W-1:0], {BIT_W{1'b0}}} + POS_W'(1);
        else
            new_start = '0;
    end

    assign pos_inc = (pos_q == POS_MAX) ? pos_q : pos_q + POS_W'(1);

    // Next-state process
    always_comb begin
        state_n = state_q;
        pos_n   = pos_inc;
        start_n = start_q;
        sel_n   = sel_q;
        unique case (state_q)
            ST_NOSYNC: state_n = ST_NOSYNC;
            ST_LEAD:   if (pos_inc == start_q) state_n = ST_ACTIVE;
            ST_ACTIVE: if (pos_inc == start_q + SLOT_LEN) state_n = ST_TRAIL;
            ST_TRAIL:  state_n = ST_TRAIL;
        endcase
        if (frame_start) begin
            pos_n   = '0;
            start_n = new_start;
            sel_n   = pend_cfg[CFG_W-2 -: SEL_W];
            if (!new_en)
                state_n = ST_TRAIL;
            else if (new_start == '0)
                state_n = ST_ACTIVE;
            else
                state_n = ST_LEAD;
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NOSYNC;
            pos_q   <= '0;
            start_q <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
            start_q <= start_n;
            sel_q   <= sel_n;
        end
    end

    // Output process
    always_comb begin
        slot_active = 1'b0;
        bit_idx     = '0;
        slot_sel    = sel_q;
        unique case (state_q)
            ST_ACTIVE: begin
                slot_active = 1'b1;
                bit_idx     = BIT_W'(pos_q - start_q);
            end
            ST_NOSYNC, ST_LEAD, ST_TRAIL: begin
                slot_active = 1'b0;
                bit_idx     = '0;
            end
        endcase
    end

endmodule

// File: rtl/pcm_tsa_port_demux.sv
module pcm_tsa_port_demux #(
    parameter int PORTS = 2,
    localparam int SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic [PORTS-1:0] en
);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign en[p] = active && (sel == SEL_W'(p));
    end

endmodule

// File: rtl/pcm_slot_assign.sv
module pcm_slot_assign
    import pcm_tsa_pkg::*;
#(
    parameter int SLOT_W = TSA_SLOT_W,
    parameter int BIT_W  = TSA_BIT_W,
    parameter int PORTS  = TSA_PORTS,
    localparam int SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int CFG_W = SLOT_W + SEL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_tx,
    input  logic             fs_rx,
    input  logic             wr_tx,
    input  logic             wr_rx,
    input  logic             wr_mode,
    input  logic [CFG_W-1:0] wr_data,
    output logic [PORTS-1:0] tx_oe,
    output logic [BIT_W-1:0] tx_bit,
    output logic [PORTS-1:0] rx_stb,
    output logic [BIT_W-1:0] rx_bit
);

    localparam int DIRS = 2; // 0 = transmit, 1 = receive

    logic [CFG_W-1:0] pend_tx, pend_rx;
    timing_mode_e     pend_mode;

    logic [DIRS-1:0]             fs_vec;
    logic [DIRS-1:0][CFG_W-1:0]  pend_vec;
    logic [DIRS-1:0]             start_vec;
    logic [DIRS-1:0]             active_vec;
    logic [DIRS-1:0][SEL_W-1:0]  sel_vec;
    logic [DIRS-1:0][BIT_W-1:0]  bit_vec;
    logic [DIRS-1:0][PORTS-1:0]  en_vec;

    pcm_tsa_cfg_regs #(.CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_tx     (wr_tx),
        .wr_rx     (wr_rx),
        .wr_mode   (wr_mode),
        .wr_data   (wr_data),
        .pend_tx   (pend_tx),
        .pend_rx   (pend_rx),
        .pend_mode (pend_mode)
    );

    assign fs_vec   = {fs_rx, fs_tx};
    assign pend_vec = {pend_rx, pend_tx};

    for (genvar d = 0; d < DIRS; d++) begin : g_dir
        pcm_tsa_frame_edge u_edge (
            .clk         (clk),
            .rst_n       (rst_n),
            .fs          (fs_vec[d]),
            .frame_start (start_vec[d])
        );

        pcm_tsa_slot_engine #(
            .SLOT_W (SLOT_W),
            .BIT_W  (BIT_W),
            .SEL_W  (SEL_W)
        ) u_engine (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (start_vec[d]),
            .pend_cfg    (pend_vec[d]),
            .pend_mode   (pend_mode),
            .slot_active (active_vec[d]),
            .slot_sel    (sel_vec[d]),
            .bit_idx     (bit_vec[d])
        );

        pcm_tsa_port_demux #(.PORTS(PORTS)) u_demux (
            .active (active_vec[d]),
            .sel    (sel_vec[d]),
            .en     (en_vec[d])
        );
    end

    assign tx_oe  = en_vec[0];
    assign tx_bit = bit_vec[0];
    assign rx_stb = en_vec[1];
    assign rx_bit = bit_vec[1];

endmodule

// File: rtl/pcm_slot_assign_chk.sv
module pcm_slot_assign_chk #(
    parameter int PORTS = 2,
    parameter int BIT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fs_tx,
    input logic             fs_rx,
    input logic [PORTS-1:0] tx_oe,
    input logic [BIT_W-1:0] tx_bit,
    input logic [PORTS-1:0] rx_stb,
    input logic [BIT_W-1:0] rx_bit
);

    localparam int LEN = 1 << BIT_W;

    logic       tx_fs_q, rx_fs_q, tx_seen, rx_seen;
    logic [7:0] tx_run, rx_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_fs_q <= 1'b0;
            rx_fs_q <= 1'b0;
            tx_seen <= 1'b0;
            rx_seen <= 1'b0;
            tx_run  <= '0;
            rx_run  <= '0;
        end else begin
            tx_fs_q <= fs_tx;
            rx_fs_q <= fs_rx;
            if (fs_tx && !tx_fs_q) tx_seen <= 1'b1;
            if (fs_rx && !rx_fs_q) rx_seen <= 1'b1;
            if (fs_tx && !tx_fs_q) tx_run <= '0;
            else if (tx_oe != '0)  tx_run <= tx_run + 8'd1;
            else                   tx_run <= '0;
            if (fs_rx && !rx_fs_q) rx_run <= '0;
            else if (rx_stb != '0) rx_run <= rx_run + 8'd1;
            else                   rx_run <= '0;
        end
    end

    p_tx_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_seen |-> (tx_oe == '0));
    p_rx_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_seen |-> (rx_stb == '0));
    p_tx_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe != '0) |-> (tx_run < 8'(LEN)));
    p_rx_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb != '0) |-> (rx_run < 8'(LEN)));
    p_tx_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_oe));
    p_rx_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_stb));
    p_tx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe == '0) |-> (tx_bit == '0));
    p_rx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb == '0) |-> (rx_bit == '0));
    p_tx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_oe) != '0 && tx_oe != '0)
        |-> (tx_bit == $past(tx_bit) + BIT_W'(1) || tx_bit == '0));
    p_rx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_stb) != '0 && rx_stb != '0)
        |-> (rx_bit == $past(rx_bit) + BIT_W'(1) || rx_bit == '0));
    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_oe) != '0 && tx_oe != '0 && tx_bit != '0) |-> (tx_oe == $past(tx_oe)));
    p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_stb) != '0 && rx_stb != '0 && rx_bit != '0) |-> (rx_stb == $past(rx_stb)));

endmodule

bind pcm_slot_assign pcm_slot_assign_chk #(.PORTS(PORTS), .BIT_W(BIT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .fs_tx  (fs_tx),
    .fs_rx  (fs_rx),
    .tx_oe  (tx_oe),
    .tx_bit (tx_bit),
    .rx_stb (rx_stb),
    .rx_bit (rx_bit)
);

// File: tb/pcm_slot_assign_tb.sv
module pcm_slot_assign_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fs_tx = 1'b0, fs_rx = 1'b0;
    logic       wr_tx = 1'b0, wr_rx = 1'b0, wr_mode = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] tx_oe, rx_stb;
    logic [2:0] tx_bit, rx_bit;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] pend_tx = '0, pend_rx = '0;
    logic       pend_md = 1'b0;

    always #5 clk = ~clk;

    pcm_slot_assign u_dut (
        .clk(clk), .rst_n(rst_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .wr_tx(wr_tx), .wr_rx(wr_rx), .wr_mode(wr_mode), .wr_data(wr_data),
        .tx_oe(tx_oe), .tx_bit(tx_bit), .rx_stb(rx_stb), .rx_bit(rx_bit)
    );

    function automatic int slot_start(input logic [7:0] b, input logic md);
        return md ? 8 * int'(b[5:0]) + 1 : 0;
    endfunction

    function automatic logic [4:0] expect_out(input logic [7:0] b, input logic md, input int p);
        int s = slot_start(b, md);
        if (!b[7] || p < s || p >= s + 8) return 5'd0;
        return {(b[6] ? 2'b10 : 2'b01), 3'(p - s)};
    endfunction

    task automatic check(input string what, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got en=%b bit=%0d, expected en=%b bit=%0d",
                     what, act[4:3], act[2:0], exp[4:3], exp[2:0]);
        end
    endtask

    task automatic write_reg(input int which, input logic [7:0] v);
        @(negedge clk);
        wr_data = v;
        wr_tx   = (which == 0);
        wr_rx   = (which == 1);
        wr_mode = (which == 2);
        @(negedge clk);
        wr_tx = 1'b0; wr_rx = 1'b0; wr_mode = 1'b0;
        if (which == 0) pend_tx = v;
        else if (which == 1) pend_rx = v;
        else pend_md = v[0];
    endtask

    // One frame per direction; rx sync lags tx by d cycles, both held high w cycles.
    task automatic run_frame(input logic [7:0] tb, input logic [7:0] rb, input logic md,
                             input int d, input int w, input logic do_wr,
                             input int mid_j, input logic [7:0] mid_b, input string tag);
        logic [7:0] a_tx, a_rx;
        logic       a_md;
        int         span;
        if (do_wr) begin
            write_reg(0, tb);
            write_reg(1, rb);
            write_reg(2, {7'd0, md});
        end
        a_tx = pend_tx; a_rx = pend_rx; a_md = pend_md;
        span = slot_start(a_tx, a_md) > slot_start(a_rx, a_md) ?
               slot_start(a_tx, a_md) : slot_start(a_rx, a_md);
        span = span + d + w + 12;
        for (int j = 0; j <= span; j++) begin
            @(negedge clk);
            check({tag, " tx"}, {tx_oe, tx_bit}, expect_out(a_tx, a_md, j - 1));
            check({tag, " rx R10"}, {rx_stb, rx_bit}, expect_out(a_rx, a_md, j - 1 - d));
            fs_tx = (j < w);
            fs_rx = (j >= d) && (j < d + w);
            if (j == mid_j) begin
                wr_data = mid_b; wr_tx = 1'b1; pend_tx = mid_b;
            end else begin
                wr_tx = 1'b0;
            end
        end
        fs_tx = 1'b0; fs_rx = 1'b0; wr_tx = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: quiet after reset
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R2 reset tx", {tx_oe, tx_bit}, 5'd0);
            check("R2 reset rx", {rx_stb, rx_bit}, 5'd0);
        end
        // R2/R6: frames with power-on settings
        run_frame(8'h00, 8'h00, 1'b0, 1, 1, 1'b0, -1, 8'h00, "R2/R6 power-on");
        // R4/R7/R1/R11: fixed timing, slot number ignored
        for (int e = 0; e < 2; e++)
            for (int s = 0; s < 2; s++)
                run_frame({e[0], s[0], 6'd37}, {e[0], ~s[0], 6'd5}, 1'b0, 2, 1, 1'b1,
                          -1, 8'h00, "R4/R7/R1/R11 fixed");
        // R5/R7/R8/R3/R10/R11: all slots in assigned timing
        for (int s = 0; s < 64; s++)
            run_frame({1'b1, s[0], 6'(s)}, {1'b1, ~s[0], 6'(63 - s)}, 1'b1, s % 4, 1 + s % 3,
                      1'b1, -1, 8'h00, "R5/R7/R8/R3 assigned");
        // R6: disabled in assigned timing
        run_frame(8'h05, 8'h45, 1'b1, 0, 1, 1'b1, -1, 8'h00, "R6 disabled");
        // R9: mid-frame write holds until next frame
        run_frame({2'b10, 6'd2}, {2'b11, 6'd3}, 1'b1, 0, 1, 1'b1, 6, {2'b11, 6'd1},
                  "R9 mid-write");
        run_frame(8'h00, 8'h00, 1'b1, 0, 1, 1'b0, -1, 8'h00, "R9 next-frame");
        // R11: back to fixed timing
        run_frame({2'b11, 6'd9}, {2'b10, 6'd4}, 1'b0, 3, 2, 1'b1, -1, 8'h00, "R11 fixed again");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule